// File: doc/BRIEF.md
# Scaled PWM Clock Generator

This block turns a base clock-enable pulse (clock A) into a slower scaled clock S0, and from either of the two it builds the input clock for one PWM channel. An 8-bit scale value sets a down-counter that emits one tick after every scale+1 clock A pulses. A toggle stage then halves that rate. Every clock is a single-cycle enable pulse in the system clock domain, so no derived clock net exists.

A write to the scale value restarts the division at once. The write still updates the value, but it leaves the running count alone when special mode is active and the hold test input is set. A free-running 7-bit prescale counter runs beside the divider. The channel output is gated by an enable, and a newly enabled channel starts only on a tick of its selected source clock.

Top module: `pwm_scaled_clk`

## Requirements
- R1: After reset, `scale_q`, `pre_q` and `chan_active` are 0, and `s0_tick` and `chan_clk_tick` are low.
- R2: `pre_q` increases by one on every system clock cycle and wraps from 127 to 0.
- R3: A prescale write (`pre_wr`) loads `pre_wdata` on the next edge only while `special_mode` is 1. With `special_mode` at 0 the write has no effect and counting continues.
- R4: With scale value N, `s0_tick` pulses once for every 2*(N+1) `clka_tick` pulses, counted from the last reload. A `s0_tick` pulse only occurs in a cycle in which `clka_tick` is high.
- R5: The scale value 255 gives one `s0_tick` every 512 clock A pulses.
- R6: A `scale_wr` updates `scale_q` on the next edge. It also reloads the scaler count with the new value and clears the divide-by-two stage, so the next `s0_tick` comes 2*(N+1) clock A pulses later.
- R7: While `special_mode` and `scale_hold` are both 1, a `scale_wr` still updates `scale_q`, but the scaler count and the toggle keep running undisturbed.
- R8: `clk_sel` = 0 selects clock A as the channel source and `clk_sel` = 1 selects S0.
- R9: After `chan_en` rises, the first source tick sets `chan_active` and is not passed on. Every later source tick appears on `chan_clk_tick` in its own cycle.
- R10: While `chan_en` is 0, `chan_clk_tick` is low, and `chan_active` is cleared on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clka_tick | input | 1 | Clock A enable pulse |
| special_mode | input | 1 | Special (test) mode |
| scale_hold | input | 1 | Suppresses the reload on a scale write in special mode |
| scale_wr | input | 1 | Scale register write strobe |
| scale_wdata | input | 8 | Scale write data |
| pre_wr | input | 1 | Prescale counter write strobe |
| pre_wdata | input | 7 | Prescale write data |
| clk_sel | input | 1 | Channel source select: 0 = clock A, 1 = S0 |
| chan_en | input | 1 | Channel enable |
| scale_q | output | 8 | Current scale value |
| pre_q | output | 7 | Prescale counter value |
| s0_tick | output | 1 | Scaled clock S0 pulse |
| chan_clk_tick | output | 1 | Gated channel clock pulse |
| chan_active | output | 1 | Channel has synchronised to its source |

## Verification
The assertions check the local cycle rules on every cycle. They cover the prescale step and its special-mode load, the scale register taking the write data, S0 pulsing only with clock A, the channel tick following the selected source, and the channel going idle after a disable. The division ratio cannot be seen within a few cycles. The bench's pulse counts over long runs show it, along with the restart on a write, the held write leaving the count undisturbed, and the first source tick after an enable being swallowed.

// File: rtl/pwm_scaled_clk.sv
module pwm_scaled_clk #(
  parameter int SCALE_W = 8,
  parameter int PRE_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clka_tick,
  input  logic               special_mode,
  input  logic               scale_hold,
  input  logic               scale_wr,
  input  logic [SCALE_W-1:0] scale_wdata,
  input  logic               pre_wr,
  input  logic [PRE_W-1:0]   pre_wdata,
  input  logic               clk_sel,
  input  logic               chan_en,
  output logic [SCALE_W-1:0] scale_q,
  output logic [PRE_W-1:0]   pre_q,
  output logic               s0_tick,
  output logic               chan_clk_tick,
  output logic               chan_active
);

  logic [SCALE_W-1:0] scale_r, cnt_r;
  logic [PRE_W-1:0]   pre_r;
  logic               tgl_r, act_r;

  wire reload   = scale_wr && !(special_mode && scale_hold);
  wire div_tick = clka_tick && (cnt_r == '0) && !reload;
  wire src_tick = clk_sel ? s0_tick : clka_tick;

  assign s0_tick       = div_tick && tgl_r;
  assign chan_clk_tick = chan_en && act_r && src_tick;
  assign chan_active   = act_r;
  assign scale_q       = scale_r;
  assign pre_q         = pre_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_r <= '0;
    else if (special_mode && pre_wr)
      pre_r <= pre_wdata;
    else
      pre_r <= pre_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      scale_r <= '0;
    else if (scale_wr)
      scale_r <= scale_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= '0;
      tgl_r <= 1'b0;
    end else if (reload) begin
      cnt_r <= scale_wdata;
      tgl_r <= 1'b0;
    end else if (div_tick) begin
      cnt_r <= scale_r;
      tgl_r <= ~tgl_r;
    end else if (clka_tick) begin
      cnt_r <= cnt_r - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act_r <= 1'b0;
    else if (!chan_en)
      act_r <= 1'b0;
    else if (src_tick)
      act_r <= 1'b1;
  end

endmodule

module pwm_scaled_clk_chk #(
  parameter int SCALE_W = 8,
  parameter int PRE_W   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clka_tick,
  input logic               special_mode,
  input logic               scale_wr,
  input logic [SCALE_W-1:0] scale_wdata,
  input logic               pre_wr,
  input logic [PRE_W-1:0]   pre_wdata,
  input logic               clk_sel,
  input logic               chan_en,
  input logic [SCALE_W-1:0] scale_q,
  input logic [PRE_W-1:0]   pre_q,
  input logic               s0_tick,
  input logic               chan_clk_tick,
  input logic               chan_active
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  // R2
  pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(special_mode && pre_wr) |-> pre_q == PRE_W'($past(pre_q) + 1'b1));

  // R3
  pre_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    special_mode && pre_wr |=> pre_q == $past(pre_wdata));

  // R6
  scale_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scale_wr |=> scale_q == $past(scale_wdata));

  // R4
  s0_in_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s0_tick |-> clka_tick);

  // R8
  chan_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clk_tick |-> (clk_sel ? s0_tick : clka_tick));

  // R9
  chan_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clk_tick |-> chan_active && chan_en);

  // R10
  chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !chan_active);

endmodule

bind pwm_scaled_clk pwm_scaled_clk_chk #(.SCALE_W(SCALE_W), .PRE_W(PRE_W)) u_chk (.*);

// File: tb/tb_pwm_scaled_clk.sv
module tb_pwm_scaled_clk;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clka_tick = 0, special_mode = 0, scale_hold = 0, scale_wr = 0;
  logic [7:0] scale_wdata = 0;
  logic pre_wr = 0;
  logic [6:0] pre_wdata = 0;
  logic clk_sel = 0, chan_en = 0;
  logic [7:0] scale_q;
  logic [6:0] pre_q;
  logic s0_tick, chan_clk_tick, chan_active;

  int n_chk = 0, n_bad = 0, s0_cnt = 0, ch_cnt = 0;
  logic [6:0] p0;

  always #5 clk = ~clk;

  pwm_scaled_clk dut (.*);

  always @(negedge clk) begin
    if (s0_tick) s0_cnt++;
    if (chan_clk_tick) ch_cnt++;
  end

  // {scale, clock A pulses, expected S0 pulses}  (R4, R5)
  localparam int VEC [7][3] = '{
    '{0, 10, 5}, '{1, 16, 4}, '{2, 11, 1}, '{2, 12, 2},
    '{4, 30, 3}, '{255, 512, 1}, '{255, 511, 0}};

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic a_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 clka_tick = 1;
      @(posedge clk); #1 clka_tick = 0;
    end
    @(negedge clk);
  endtask

  task automatic wr_scale(logic [7:0] v, logic hold);
    @(posedge clk); #1 scale_wr = 1; scale_wdata = v; special_mode = hold; scale_hold = hold;
    @(posedge clk); #1 scale_wr = 0; special_mode = 0; scale_hold = 0;
  endtask

  task automatic clr_cnt();
    @(posedge clk); #1 s0_cnt = 0; ch_cnt = 0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    check("R1 scale_q", scale_q, 0);
    check("R1 pre_q", pre_q, 0);
    check("R1 chan_active", chan_active, 0);
    check("R1 s0_tick", s0_tick, 0);
    check("R1 chan_clk_tick", chan_clk_tick, 0);
    #20 rst_n = 1;

    // R4: reset state divides by 2*(0+1)
    clr_cnt(); a_ticks(4);
    check("R4 reset-state S0 count", s0_cnt, 2);

    // R2: step of one per cycle
    @(negedge clk) p0 = pre_q;
    repeat (5) @(negedge clk);
    check("R2 prescale step", pre_q, 7'(p0 + 5));

    // R3: write ignored outside special mode
    @(negedge clk) p0 = pre_q;
    @(posedge clk); #1 pre_wr = 1; pre_wdata = 7'h40;
    @(posedge clk); #1 pre_wr = 0;
    @(negedge clk);
    check("R3 write ignored", pre_q, 7'(p0 + 2));

    // R3 and R2 wrap: special write of 127 then wrap to 0
    @(posedge clk); #1 pre_wr = 1; pre_wdata = 7'h7F; special_mode = 1;
    @(posedge clk); #1 pre_wr = 0; special_mode = 0;
    @(negedge clk);
    check("R3 special write", pre_q, 127);
    @(negedge clk);
    check("R2 wrap", pre_q, 0);

    // R4, R5, R6: vector table
    foreach (VEC[i]) begin
      wr_scale(8'(VEC[i][0]), 1'b0);
      @(negedge clk);
      check("R6 scale_q", scale_q, VEC[i][0]);
      clr_cnt(); a_ticks(VEC[i][1]);
      check(VEC[i][0] == 255 ? "R5 S0 count" : "R4 S0 count", s0_cnt, VEC[i][2]);
    end

    // R6: normal write restarts division
    wr_scale(8'd3, 1'b0); a_ticks(7);
    wr_scale(8'd5, 1'b0);
    clr_cnt(); a_ticks(1);
    check("R6 restart on write", s0_cnt, 0);

    // R7: held write keeps running count
    wr_scale(8'd3, 1'b0); a_ticks(7);
    wr_scale(8'd5, 1'b1);
    @(negedge clk);
    check("R7 scale_q updated", scale_q, 5);
    clr_cnt(); a_ticks(1);
    check("R7 count undisturbed", s0_cnt, 1);

    // R9, R8: clock A source
    clk_sel = 0;
    @(posedge clk); #1 chan_en = 1;
    @(negedge clk);
    check("R9 not active before tick", chan_active, 0);
    clr_cnt(); a_ticks(5);
    check("R9 R8 clock A channel ticks", ch_cnt, 4);
    check("R9 active", chan_active, 1);

    // R10: disable
    @(posedge clk); #1 chan_en = 0;
    @(negedge clk); @(negedge clk);
    check("R10 active cleared", chan_active, 0);
    clr_cnt(); a_ticks(3);
    check("R10 no ticks", ch_cnt, 0);

    // R8, R9: S0 source
    wr_scale(8'd1, 1'b0);
    @(posedge clk); #1 clk_sel = 1; chan_en = 1;
    clr_cnt(); a_ticks(16);
    check("R8 S0 pulses", s0_cnt, 4);
    check("R8 R9 S0 channel ticks", ch_cnt, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule